// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog Timer

This block is a watchdog that runs from a low-speed clock. A prescaler divides that clock into a slow tick, and a tick counter measures how long it has been since software last proved it was alive. Software proves this by writing a two-byte key to a control register. A one-bit pointer, which flips on every control write, decides whether the byte is read as the first key or the second. Only the pair 0x5A then 0xA5 restarts the counter.

If the counter runs out, the watchdog first raises a one-cycle interrupt so that software can recover. If the next period also runs out without a restart, the block raises a reset request. That request stays high until the system reset is applied. A 2-bit mode register picks one of four periods, each four times the one before it. A new mode is held back until the next restart, so a period that has already begun is never cut short. Software should restart the counter at least one tick before the period ends.

Top module: `keyed_watchdog`

## Requirements
- R1: While `rstN` is low, `wdtIrq` and `wdtRstReq` are 0. When `rstN` is released, the key pointer is 0, the counter and prescaler are 0, and both the active mode and the pending mode are 0.
- R2: The prescaler and counter advance only on clock cycles where `oscRun` is 1. While `oscRun` is 0 they hold their values, so no overflow can occur.
- R3: With active mode m (0..3), an overflow occurs on the PRESCALE*BASE_TICKS*4^m-th counting cycle after reset release or after a restart. With the default parameters this is 4096, 16384, 65536 or 262144 cycles. After an overflow the counter starts the same period again.
- R4: A control write (`wrEn`=1, `wrSel`=0) of 0xA5 restarts the counter and prescaler only if the pointer is 1 and the write just before it was 0x5A made with the pointer at 0. Any other value, order or pointer state does not restart the counter.
- R5: Every control write inverts the key pointer, whatever data it carries. An overflow forces the pointer to 0 and discards a half-entered key. A control write made in the same cycle as an overflow is lost.
- R6: The first overflow since reset or since the last restart sets `wdtIrq` high for exactly one cycle, in the cycle after the overflow edge.
- R7: A second overflow with no restart in between sets `wdtRstReq` high in the cycle after the overflow edge. It then stays high, through later restarts, until `rstN` goes low.
- R8: A restart clears the record of an earlier overflow. The next overflow after a restart therefore raises `wdtIrq` again and not `wdtRstReq`.
- R9: A mode write (`wrEn`=1, `wrSel`=1) stores `wrData[1:0]` as the pending mode. The pending mode becomes the active mode only at the next restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Low-speed clock |
| rstN | input | 1 | Active-low system reset |
| oscRun | input | 1 | High when the low-speed oscillator is running |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 = control (key), 1 = mode |
| wrData | input | 8 | Write data; mode uses bits [1:0] |
| wdtIrq | output | 1 | One-cycle watchdog interrupt pulse |
| wdtRstReq | output | 1 | Sticky reset request |

## Verification
The bench aims at the exact overflow cycle for each mode. A period that is off by one tick or one prescaler cycle would move the interrupt pulse away from the sampled cycle.

Key handling is attacked in several ways:
- A random mix of first keys, second keys and junk bytes. A design that restarts on a lone 0xA5, or ignores the pointer, would hold the interrupt back when it is due.
- A key pair split by an overflow. This would wrongly restart a design that does not reset the pointer.
- A mode write with no restart after it. A design that applies the mode at once would stretch or shorten the running period.
- A restart after an interrupt. A design that keeps the escalation state would request reset too early.

// File: rtl/kwdt_pkg.sv
`timescale 1ns/1ps
package kwdt_pkg;
  // Strobes from the control side to the datapath.
  typedef struct packed {
    logic clear;     // restart counter and prescaler, adopt pending mode
    logic loadMode;  // capture a new pending mode
  } kwdtStrobe_t;
endpackage

// File: rtl/kwdt_ctrl.sv
`timescale 1ns/1ps
module kwdt_ctrl
  import kwdt_pkg::*;
#(
  parameter logic [7:0] KEY_FIRST  = 8'h5A,
  parameter logic [7:0] KEY_SECOND = 8'hA5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic [7:0]  wrData,
  input  logic        ovf,
  output kwdtStrobe_t strobe,
  output logic        keyPtr,
  output logic        irqOut,
  output logic        rstReqOut
);
  logic ptr;
  logic firstOk;
  logic ovfSeen;
  logic irqQ;
  logic rstQ;
  logic ctlWr;
  logic keyMatch;

  assign ctlWr    = wrEn && !wrSel;
  assign keyMatch = ctlWr && ptr && firstOk && (wrData == KEY_SECOND);

  always_comb begin
    strobe          = '0;
    strobe.clear    = keyMatch;
    strobe.loadMode = wrEn && wrSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= 1'b0;
      firstOk <= 1'b0;
      ovfSeen <= 1'b0;
      irqQ    <= 1'b0;
      rstQ    <= 1'b0;
    end else begin
      irqQ <= 1'b0;
      if (ovf) begin
        // overflow discards any half-entered key
        ptr     <= 1'b0;
        firstOk <= 1'b0;
        if (!ovfSeen) begin
          ovfSeen <= 1'b1;
          irqQ    <= 1'b1;
        end else begin
          rstQ <= 1'b1;
        end
      end else if (ctlWr) begin
        ptr     <= ~ptr;
        firstOk <= !ptr && (wrData == KEY_FIRST);
        if (keyMatch) ovfSeen <= 1'b0;
      end
    end
  end

  assign keyPtr    = ptr;
  assign irqOut    = irqQ;
  assign rstReqOut = rstQ;
endmodule

// File: rtl/kwdt_datapath.sv
`timescale 1ns/1ps
module kwdt_datapath
  import kwdt_pkg::*;
#(
  parameter int PRESCALE   = 128,
  parameter int BASE_TICKS = 32,
  localparam int PRE_W     = $clog2(PRESCALE),
  localparam int MAX_TICKS = BASE_TICKS * 64,
  localparam int CNT_W     = $clog2(MAX_TICKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oscRun,
  input  kwdtStrobe_t      strobe,
  input  logic [1:0]       modeIn,
  output logic             ovf,
  output logic [CNT_W-1:0] cntVal,
  output logic [PRE_W-1:0] preVal
);
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       pendMode;
  logic [1:0]       actMode;
  logic [CNT_W-1:0] limitTbl [4];
  logic             tick;
  logic             atLimit;

  // last tick index of each period, each mode four times the previous one
  for (genvar m = 0; m < 4; m++) begin : g_limit
    assign limitTbl[m] = CNT_W'(BASE_TICKS * (4 ** m) - 1);
  end

  assign tick    = oscRun && (pre == PRE_W'(PRESCALE - 1));
  assign atLimit = (cnt == limitTbl[actMode]);
  assign ovf     = tick && atLimit && !strobe.clear;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre     <= '0;
      cnt     <= '0;
      actMode <= 2'd0;
    end else if (strobe.clear) begin
      pre     <= '0;
      cnt     <= '0;
      actMode <= pendMode;
    end else if (oscRun) begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) cnt <= atLimit ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pendMode <= 2'd0;
    else if (strobe.loadMode) pendMode <= modeIn;
  end

  assign cntVal = cnt;
  assign preVal = pre;
endmodule

// File: rtl/keyed_watchdog.sv
`timescale 1ns/1ps
module keyed_watchdog
  import kwdt_pkg::*;
#(
  parameter int         PRESCALE   = 128,
  parameter int         BASE_TICKS = 32,
  parameter logic [7:0] KEY_FIRST  = 8'h5A,
  parameter logic [7:0] KEY_SECOND = 8'hA5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscRun,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic [7:0] wrData,
  output logic       wdtIrq,
  output logic       wdtRstReq
);
  localparam int PRE_W = $clog2(PRESCALE);
  localparam int CNT_W = $clog2(BASE_TICKS * 64);

  kwdtStrobe_t      strobe;
  logic             ovf;
  logic             keyPtr;
  logic [CNT_W-1:0] cntVal;
  logic [PRE_W-1:0] preVal;

  kwdt_ctrl #(
    .KEY_FIRST (KEY_FIRST),
    .KEY_SECOND(KEY_SECOND)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrData   (wrData),
    .ovf      (ovf),
    .strobe   (strobe),
    .keyPtr   (keyPtr),
    .irqOut   (wdtIrq),
    .rstReqOut(wdtRstReq)
  );

  kwdt_datapath #(
    .PRESCALE  (PRESCALE),
    .BASE_TICKS(BASE_TICKS)
  ) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .oscRun(oscRun),
    .strobe(strobe),
    .modeIn(wrData[1:0]),
    .ovf   (ovf),
    .cntVal(cntVal),
    .preVal(preVal)
  );
endmodule

// File: rtl/kwdt_checker.sv
`timescale 1ns/1ps
module kwdt_checker
  import kwdt_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int PRE_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             oscRun,
  input logic             wrEn,
  input logic             wrSel,
  input logic             wdtIrq,
  input logic             wdtRstReq,
  input logic             ovf,
  input logic             keyPtr,
  input kwdtStrobe_t      strobe,
  input logic [CNT_W-1:0] cntVal,
  input logic [PRE_W-1:0] preVal
);
  // R6: interrupt lasts one cycle
  a_r6_irq_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    wdtIrq |=> !wdtIrq);

  // R6: interrupt appears just after the counter wrapped
  a_r6_irq_after_wrap: assert property (@(posedge clk) disable iff (!rstN)
    wdtIrq |-> (cntVal == '0));

  // R7: reset request is sticky
  a_r7_rstreq_holds: assert property (@(posedge clk) disable iff (!rstN)
    wdtRstReq |=> wdtRstReq);

  // R4: a restart strobe zeroes the counter and prescaler
  a_r4_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (cntVal == '0 && preVal == '0));

  // R2: nothing advances while the oscillator is not running
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!oscRun && !strobe.clear) |=> ($stable(cntVal) && $stable(preVal)));

  // R5: every control write flips the pointer unless an overflow hits
  a_r5_ptr_flips: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel && !ovf) |=> (keyPtr != $past(keyPtr)));

  // R5: an overflow leaves the pointer at zero
  a_r5_ptr_zero_after_ovf: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> !keyPtr);
endmodule

bind keyed_watchdog kwdt_checker #(.CNT_W(CNT_W), .PRE_W(PRE_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .oscRun   (oscRun),
  .wrEn     (wrEn),
  .wrSel    (wrSel),
  .wdtIrq   (wdtIrq),
  .wdtRstReq(wdtRstReq),
  .ovf      (ovf),
  .keyPtr   (keyPtr),
  .strobe   (strobe),
  .cntVal   (cntVal),
  .preVal   (preVal)
);

// File: tb/keyed_watchdog_tb_top.sv
`timescale 1ns/1ps
module keyed_watchdog_tb_top;
  localparam int P = 4;
  localparam int B = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       oscRun = 1'b1;
  logic       wrEn = 1'b0;
  logic       wrSel = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       wdtIrq;
  logic       wdtRstReq;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int rel = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  keyed_watchdog #(.PRESCALE(P), .BASE_TICKS(B)) dut_i (
    .clk(clk), .rstN(rstN), .oscRun(oscRun), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .wdtIrq(wdtIrq), .wdtRstReq(wdtRstReq)
  );

  function automatic int periodOf(int m);
    return P * B * (4 ** m);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic waitTo(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; wrEn = 1'b0; oscRun = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", int'(wdtIrq), 0);
    chk("R1 rstReq in reset", int'(wdtRstReq), 0);
    rstN = 1'b1;
    rel = cyc;
  endtask

  task automatic ctlWrite(logic [7:0] d);
    wrEn = 1'b1; wrSel = 1'b0; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic modeWrite(int m);
    wrEn = 1'b1; wrSel = 1'b1; wrData = 8'(m);
    @(negedge clk);
    wrEn = 1'b0; wrSel = 1'b0;
  endtask

  task automatic goodClear(output int edgeAt);
    ctlWrite(8'h5A);
    ctlWrite(8'hA5);
    edgeAt = cyc;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    finish();
  end

  initial begin
    int t0;
    int c;
    int c2;
    void'($urandom(32'd1234));
    t0 = periodOf(0);
    @(negedge clk);

    // R3/R6/R7: free-running escalation
    doReset();
    waitTo(rel + t0 - 1); chk("R3 no irq before period", int'(wdtIrq), 0);
    waitTo(rel + t0);     chk("R3 R6 irq at period end", int'(wdtIrq), 1);
    waitTo(rel + t0 + 1); chk("R6 irq single cycle", int'(wdtIrq), 0);
    waitTo(rel + 2*t0 - 1); chk("R7 no rstReq early", int'(wdtRstReq), 0);
    waitTo(rel + 2*t0);   chk("R7 rstReq on 2nd overflow", int'(wdtRstReq), 1);
    chk("R7 no irq on 2nd overflow", int'(wdtIrq), 0);
    goodClear(c);
    waitTo(c + 3*t0);     chk("R7 rstReq sticky", int'(wdtRstReq), 1);

    // R2: oscillator gate
    doReset();
    oscRun = 1'b0;
    waitTo(rel + 3*t0);
    chk("R2 no irq while idle", int'(wdtIrq), 0);
    chk("R2 no rstReq while idle", int'(wdtRstReq), 0);
    oscRun = 1'b1; c = cyc;
    waitTo(c + t0 - 1); chk("R2 no irq early", int'(wdtIrq), 0);
    waitTo(c + t0);     chk("R2 irq after oscRun", int'(wdtIrq), 1);

    // R4/R8: restart at the last moment, then after an interrupt
    doReset();
    waitTo(rel + t0 - 3);
    goodClear(c);
    waitTo(rel + t0);     chk("R4 restart defers irq", int'(wdtIrq), 0);
    waitTo(c + t0 - 1);   chk("R4 no irq before new period", int'(wdtIrq), 0);
    waitTo(c + t0);       chk("R4 irq after restart period", int'(wdtIrq), 1);
    goodClear(c2);
    waitTo(c2 + t0);      chk("R8 irq again after restart", int'(wdtIrq), 1);
    chk("R8 no rstReq after restart", int'(wdtRstReq), 0);

    // R5: key pair split by overflow does not restart
    doReset();
    waitTo(rel + t0 - 2);
    ctlWrite(8'h5A);
    waitTo(rel + t0);     chk("R5 irq on overflow", int'(wdtIrq), 1);
    ctlWrite(8'hA5);
    waitTo(rel + 2*t0);   chk("R5 split key no restart", int'(wdtRstReq), 1);

    // R9: mode change deferred to next restart
    doReset();
    modeWrite(1);
    waitTo(rel + t0);     chk("R9 mode not yet active", int'(wdtIrq), 1);
    goodClear(c);
    waitTo(c + t0);       chk("R9 old period gone", int'(wdtIrq), 0);
    waitTo(c + periodOf(1) - 1); chk("R9 R3 mode1 early", int'(wdtIrq), 0);
    waitTo(c + periodOf(1)); chk("R9 R3 mode1 period", int'(wdtIrq), 1);
    for (int m = 2; m < 4; m++) begin
      modeWrite(m);
      goodClear(c);
      waitTo(c + periodOf(m) - 1); chk("R3 mode period early", int'(wdtIrq), 0);
      waitTo(c + periodOf(m));     chk("R3 mode period end", int'(wdtIrq), 1);
    end

    // R4/R5: random key sequences against a pointer model
    for (int trial = 0; trial < 40; trial++) begin
      bit ptrM;
      bit okM;
      int clrAt;
      int d;
      int n;
      doReset();
      ptrM = 1'b0; okM = 1'b0; clrAt = -1;
      d = 2 + $urandom_range(0, 5);
      n = 1 + $urandom_range(0, 2);
      waitTo(rel + d);
      for (int k = 0; k < n; k++) begin
        logic [7:0] v;
        case ($urandom_range(0, 3))
          0: v = 8'h5A;
          1: v = 8'hA5;
          2: v = 8'($urandom_range(0, 255));
          default: v = ptrM ? 8'hA5 : 8'h5A;
        endcase
        ctlWrite(v);
        if (clrAt < 0 && ptrM && okM && v == 8'hA5) clrAt = cyc;
        okM  = !ptrM && (v == 8'h5A);
        ptrM = !ptrM;
      end
      waitTo(rel + t0);
      chk("R4 R5 random key irq", int'(wdtIrq), (clrAt < 0) ? 1 : 0);
      if (clrAt >= 0) begin
        waitTo(clrAt + t0);
        chk("R4 random restart period", int'(wdtIrq), 1);
      end
    end

    finish();
  end
endmodule